// File: doc/BRIEF.md
# Dual-View General Register File

This block is a 64-entry by 64-bit integer register file with two combinational wide read ports and one wide write port. The same storage also appears through a narrow view. That view covers only entries 0 to 15 and is 32 bits wide. It has its own read port and its own write port. A narrow read returns the lower half of the selected entry. A narrow write stores the 32-bit value sign-extended to 64 bits. The highest entry is a constant zero: it always reads as zero and it discards every write aimed at it.

A small write selector settles, in each cycle, which view may commit. It has three named states. `WR_IDLE` means no write this cycle. `WR_WIDE` means the wide port commits. `WR_NARROW` means the narrow port commits. The selection is made fresh every cycle:
- When the wide enable is high, the selector moves to `WR_WIDE`, whatever the narrow enable is.
- When only the narrow enable is high, the selector moves to `WR_NARROW`.
- When neither enable is high, the selector returns to `WR_IDLE`.

The chosen write lands on the rising clock edge. Reads are combinational from the stored state, so a read in the same cycle as a write to the same entry sees the old value. An active-low asynchronous reset clears every entry.

Top module: `dual_view_regfile`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, every entry reads as zero on every read port.
- R2: With the wide enable high, the wide data is stored at the wide index on the rising edge. From the next cycle it reads back on the wide read ports.
- R3: Wide index 63 always reads as 64'h0 on both wide read ports.
- R4: A wide write to index 63 changes no entry, and index 63 still reads as zero afterwards.
- R5: The narrow read port returns bits [31:0] of the entry selected by its 4-bit index, where index k is the same storage as wide index k.
- R6: A narrow write stores the 32-bit value with bit 31 copied into bits [63:32]. For example, 32'h8000_0001 reads back wide as 64'hFFFF_FFFF_8000_0001, and 32'h1234_5678 reads back as 64'h0000_0000_1234_5678.
- R7: When both write enables are high in one cycle, only the wide write takes effect. The narrow target keeps its old value unless it is the same entry as the wide target.
- R8: A read of an entry in the same cycle as a write to it returns the value held before that edge.
- R9: With both write enables low, no entry changes, whatever the data and index inputs carry.
- R10: The two wide read ports select entries independently of each other and of the write port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all entries |
| wa_en | input | 1 | Wide write enable |
| wa_idx | input | 6 | Wide write index |
| wa_data | input | 64 | Wide write data |
| wn_en | input | 1 | Narrow write enable |
| wn_idx | input | 4 | Narrow write index (entries 0 to 15) |
| wn_data | input | 32 | Narrow write data, sign-extended on store |
| ra0_idx | input | 6 | Wide read port 0 index |
| ra0_data | output | 64 | Wide read port 0 data |
| ra1_idx | input | 6 | Wide read port 1 index |
| ra1_data | output | 64 | Wide read port 1 data |
| rn_idx | input | 4 | Narrow read index |
| rn_data | output | 32 | Narrow read data, low half of the entry |

## Verification
The assertions check the following on every cycle:
- Each committed wide write is present in storage one edge later.
- Each lone narrow write is stored sign-extended.
- The narrow target of a conflicting write pair is untouched.
- The top entry stays zero.
- The narrow read matches the low half of storage.
- An idle cycle leaves storage stable.

Only the bench's scenarios can show some behaviours. These are the old-value return on a same-cycle read and write, the independence of the two wide read ports, and the hidden effect of a discarded write to entry 63 on the other entries. The bench compares all three read ports against a behavioural model on every clock.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_ENTRIES        = 64;
    localparam int RF_DATA_W         = 64;
    localparam int RF_NARROW_ENTRIES = 16;
    localparam int RF_NARROW_W       = 32;

    // Which view owns the write path in the current cycle
    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_WIDE   = 2'd1,
        WR_NARROW = 2'd2
    } wr_src_e;

endpackage

// File: rtl/rf_wr_sel.sv
module rf_wr_sel
    import rf_pkg::*;
#(
    parameter int ENTRIES        = RF_ENTRIES,
    parameter int DATA_W         = RF_DATA_W,
    parameter int NARROW_ENTRIES = RF_NARROW_ENTRIES,
    parameter int NARROW_W       = RF_NARROW_W,
    localparam int IW            = $clog2(ENTRIES),
    localparam int NIW           = $clog2(NARROW_ENTRIES)
) (
    input  logic              wide_en,
    input  logic [IW-1:0]     wide_idx,
    input  logic [DATA_W-1:0] wide_data,
    input  logic              nar_en,
    input  logic [NIW-1:0]    nar_idx,
    input  logic [NARROW_W-1:0] nar_data,
    output logic              commit_en,
    output logic [IW-1:0]     commit_idx,
    output logic [DATA_W-1:0] commit_data
);

    localparam logic [IW-1:0] ZERO_IDX = IW'(ENTRIES - 1);
    localparam int            EXT_W    = DATA_W - NARROW_W;

    wr_src_e             src;
    logic [IW-1:0]       nar_idx_ext;
    logic [DATA_W-1:0]   nar_data_ext;

    assign nar_idx_ext  = {{(IW - NIW){1'b0}}, nar_idx};
    assign nar_data_ext = {{EXT_W{nar_data[NARROW_W-1]}}, nar_data};

    // Source selection: wide view has priority
    always_comb begin
        if (wide_en)      src = WR_WIDE;
        else if (nar_en)  src = WR_NARROW;
        else              src = WR_IDLE;
    end

    // Commit request per selected source
    always_comb begin
        unique case (src)
            WR_WIDE: begin
                commit_en   = (wide_idx != ZERO_IDX);
                commit_idx  = wide_idx;
                commit_data = wide_data;
            end
            WR_NARROW: begin
                commit_en   = 1'b1;
                commit_idx  = nar_idx_ext;
                commit_data = nar_data_ext;
            end
            default: begin
                commit_en   = 1'b0;
                commit_idx  = '0;
                commit_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int  ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int  DATA_W  = rf_pkg::RF_DATA_W,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IW-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [ENTRIES-1:0][DATA_W-1:0]  q
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        if (e == ENTRIES - 1) begin : g_zero
            assign q[e] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] ent_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else if (wr_en && (wr_idx == IW'(e))) begin
                    ent_q <= wr_data;
                end
            end
            assign q[e] = ent_q;
        end
    end

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
    parameter int  ENTRIES = rf_pkg::RF_ENTRIES,
    parameter int  DATA_W  = rf_pkg::RF_DATA_W,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][DATA_W-1:0] arr,
    input  logic [IW-1:0]                  idx,
    output logic [DATA_W-1:0]              data
);

    always_comb begin
        data = arr[idx];
    end

endmodule

// File: rtl/dual_view_regfile.sv
module dual_view_regfile
    import rf_pkg::*;
#(
    parameter int  ENTRIES        = RF_ENTRIES,
    parameter int  DATA_W         = RF_DATA_W,
    parameter int  NARROW_ENTRIES = RF_NARROW_ENTRIES,
    parameter int  NARROW_W       = RF_NARROW_W,
    localparam int IW             = $clog2(ENTRIES),
    localparam int NIW            = $clog2(NARROW_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wa_en,
    input  logic [IW-1:0]       wa_idx,
    input  logic [DATA_W-1:0]   wa_data,
    input  logic                wn_en,
    input  logic [NIW-1:0]      wn_idx,
    input  logic [NARROW_W-1:0] wn_data,
    input  logic [IW-1:0]       ra0_idx,
    output logic [DATA_W-1:0]   ra0_data,
    input  logic [IW-1:0]       ra1_idx,
    output logic [DATA_W-1:0]   ra1_data,
    input  logic [NIW-1:0]      rn_idx,
    output logic [NARROW_W-1:0] rn_data
);

    logic                                       commit_en;
    logic [IW-1:0]                              commit_idx;
    logic [DATA_W-1:0]                          commit_data;
    logic [ENTRIES-1:0][DATA_W-1:0]             regs_q;
    logic [NARROW_ENTRIES-1:0][NARROW_W-1:0]    nar_view;

    rf_wr_sel #(
        .ENTRIES        (ENTRIES),
        .DATA_W         (DATA_W),
        .NARROW_ENTRIES (NARROW_ENTRIES),
        .NARROW_W       (NARROW_W)
    ) u_wr_sel (
        .wide_en     (wa_en),
        .wide_idx    (wa_idx),
        .wide_data   (wa_data),
        .nar_en      (wn_en),
        .nar_idx     (wn_idx),
        .nar_data    (wn_data),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    rf_store #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_idx  (commit_idx),
        .wr_data (commit_data),
        .q       (regs_q)
    );

    // Narrow view: low half of the first entries
    for (genvar k = 0; k < NARROW_ENTRIES; k++) begin : g_nar
        assign nar_view[k] = regs_q[k][NARROW_W-1:0];
    end

    rf_rd_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd0 (
        .arr  (regs_q),
        .idx  (ra0_idx),
        .data (ra0_data)
    );

    rf_rd_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd1 (
        .arr  (regs_q),
        .idx  (ra1_idx),
        .data (ra1_data)
    );

    rf_rd_mux #(.ENTRIES(NARROW_ENTRIES), .DATA_W(NARROW_W)) u_rdn (
        .arr  (nar_view),
        .idx  (rn_idx),
        .data (rn_data)
    );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int  ENTRIES        = rf_pkg::RF_ENTRIES,
    parameter int  DATA_W         = rf_pkg::RF_DATA_W,
    parameter int  NARROW_ENTRIES = rf_pkg::RF_NARROW_ENTRIES,
    parameter int  NARROW_W       = rf_pkg::RF_NARROW_W,
    localparam int IW             = $clog2(ENTRIES),
    localparam int NIW            = $clog2(NARROW_ENTRIES)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wa_en,
    input logic [IW-1:0]                  wa_idx,
    input logic [DATA_W-1:0]              wa_data,
    input logic                           wn_en,
    input logic [NIW-1:0]                 wn_idx,
    input logic [NARROW_W-1:0]            wn_data,
    input logic [IW-1:0]                  ra0_idx,
    input logic [DATA_W-1:0]              ra0_data,
    input logic [NIW-1:0]                 rn_idx,
    input logic [NARROW_W-1:0]            rn_data,
    input logic [ENTRIES-1:0][DATA_W-1:0] regs
);

    localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);

    logic [IW-1:0]     wn_ext;
    logic [IW-1:0]     rn_ext;
    logic              last_wide, last_nar, last_both;
    logic [IW-1:0]     last_widx, last_nidx;
    logic [DATA_W-1:0] last_wdata, last_nsext, last_nold;

    assign wn_ext = {{(IW - NIW){1'b0}}, wn_idx};
    assign rn_ext = {{(IW - NIW){1'b0}}, rn_idx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wide  <= 1'b0;
            last_nar   <= 1'b0;
            last_both  <= 1'b0;
            last_widx  <= '0;
            last_nidx  <= '0;
            last_wdata <= '0;
            last_nsext <= '0;
            last_nold  <= '0;
        end else begin
            last_wide  <= wa_en;
            last_nar   <= wn_en && !wa_en;
            last_both  <= wn_en && wa_en;
            last_widx  <= wa_idx;
            last_nidx  <= wn_ext;
            last_wdata <= wa_data;
            last_nsext <= {{(DATA_W - NARROW_W){wn_data[NARROW_W-1]}}, wn_data};
            last_nold  <= regs[wn_ext];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (regs == '0)); // R1

    AST_WIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_wide && last_widx != TOP) |-> (regs[last_widx] == last_wdata)); // R2

    AST_TOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ra0_idx == TOP) |-> (ra0_data == '0)); // R3

    AST_TOP_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        regs[TOP] == '0); // R4

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rn_data == regs[rn_ext][NARROW_W-1:0]); // R5

    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        last_nar |-> (regs[last_nidx] == last_nsext)); // R6

    AST_WIDE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (last_both && last_widx != last_nidx) |-> (regs[last_nidx] == last_nold)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wa_en && !wn_en) |=> $stable(regs)); // R9

endmodule

bind dual_view_regfile rf_checker #(
    .ENTRIES        (ENTRIES),
    .DATA_W         (DATA_W),
    .NARROW_ENTRIES (NARROW_ENTRIES),
    .NARROW_W       (NARROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wa_en    (wa_en),
    .wa_idx   (wa_idx),
    .wa_data  (wa_data),
    .wn_en    (wn_en),
    .wn_idx   (wn_idx),
    .wn_data  (wn_data),
    .ra0_idx  (ra0_idx),
    .ra0_data (ra0_data),
    .rn_idx   (rn_idx),
    .rn_data  (rn_data),
    .regs     (regs_q)
);

// File: tb/dual_view_regfile_tb.sv
`timescale 1ns/1ps
module dual_view_regfile_tb;

    localparam int  N  = 64;
    localparam int  W  = 64;
    localparam int  NW = 32;
    localparam time HALF = 2ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wa_en = 1'b0;
    logic [5:0]    wa_idx = '0;
    logic [W-1:0]  wa_data = '0;
    logic          wn_en = 1'b0;
    logic [3:0]    wn_idx = '0;
    logic [NW-1:0] wn_data = '0;
    logic [5:0]    ra0_idx = '0;
    logic [5:0]    ra1_idx = '0;
    logic [3:0]    rn_idx = '0;
    logic [W-1:0]  ra0_data, ra1_data;
    logic [NW-1:0] rn_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [W-1:0] model [N];

    always #HALF clk = ~clk;

    dual_view_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wn_en(wn_en), .wn_idx(wn_idx), .wn_data(wn_data),
        .ra0_idx(ra0_idx), .ra0_data(ra0_data),
        .ra1_idx(ra1_idx), .ra1_data(ra1_data),
        .rn_idx(rn_idx), .rn_data(rn_data)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mread(input logic [5:0] i);
        return (i == 6'd63) ? '0 : model[i];
    endfunction

    // Compare all read ports against the model (pre-edge state, so R8 holds)
    task automatic compare_all();
        chk((ra0_idx == 6'd63) ? "R3 rd0" : "R2 rd0", ra0_data, mread(ra0_idx));
        chk((ra1_idx == 6'd63) ? "R3 rd1" : "R10 rd1", ra1_data, mread(ra1_idx));
        chk("R5 narrow rd", {32'h0, rn_data}, {32'h0, model[rn_idx][NW-1:0]});
    endtask

    // One clock: check at settle time, take edge, update model
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        if (rst_n) begin
            if (wa_en) begin
                if (wa_idx != 6'd63) model[wa_idx] = wa_data;
            end else if (wn_en) begin
                model[wn_idx] = {{32{wn_data[31]}}, wn_data};
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        wa_en = 1'b0; wn_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        // garbage on write inputs during reset
        wa_en = 1'b1; wa_idx = 6'd4; wa_data = 64'hDEAD_BEEF_0000_0001;
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        idle_in();
        // R1: full sweep after reset
        for (int i = 0; i < N; i++) begin
            ra0_idx = 6'(i); ra1_idx = 6'(N - 1 - i); rn_idx = 4'(i);
            #1;
            chk("R1 reset rd0", ra0_data, '0);
            #0;
            step();
        end
        // R2/R4: fill every entry, including 63
        for (int i = 0; i < N; i++) begin
            wa_en = 1'b1; wa_idx = 6'(i);
            wa_data = {32'(i) ^ 32'hA5A5_0000, 32'hC3C3_0000 + 32'(i)};
            ra0_idx = 6'(i); ra1_idx = 6'((i + 7) % N); rn_idx = 4'(i);
            step();
        end
        idle_in();
        ra0_idx = 6'd63; #1; chk("R4 top after write", ra0_data, '0);
        ra0_idx = 6'd62; #1; chk("R4 neighbour intact", ra0_data, {32'd62 ^ 32'hA5A5_0000, 32'hC3C3_0000 + 32'd62});
        step();
        // R8: read same entry as being written
        wa_en = 1'b1; wa_idx = 6'd5; wa_data = 64'h1111_2222_3333_4444; ra0_idx = 6'd5;
        #1; chk("R8 old value", ra0_data, {32'd5 ^ 32'hA5A5_0000, 32'hC3C3_0005});
        step();
        idle_in(); #1; chk("R2 new value", ra0_data, 64'h1111_2222_3333_4444);
        step();
        // R6: narrow writes, negative and positive
        wn_en = 1'b1; wn_idx = 4'd3; wn_data = 32'h8000_0001; step();
        wn_idx = 4'd4; wn_data = 32'h1234_5678; step();
        idle_in(); ra0_idx = 6'd3; ra1_idx = 6'd4; rn_idx = 4'd3;
        #1;
        chk("R6 negative sext", ra0_data, 64'hFFFF_FFFF_8000_0001);
        chk("R6 positive sext", ra1_data, 64'h0000_0000_1234_5678);
        chk("R5 narrow of sext", {32'h0, rn_data}, 64'h0000_0000_8000_0001);
        step();
        // R7: both enables high
        wa_en = 1'b1; wa_idx = 6'd7; wa_data = 64'hAAAA_BBBB_CCCC_DDDD;
        wn_en = 1'b1; wn_idx = 4'd9; wn_data = 32'hFFFF_0000;
        step();
        idle_in(); ra0_idx = 6'd7; ra1_idx = 6'd9;
        #1;
        chk("R7 wide wins", ra0_data, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R7 narrow dropped", ra1_data, {32'd9 ^ 32'hA5A5_0000, 32'hC3C3_0009});
        step();
        // R9: enables low, busy data/index
        wa_idx = 6'd7; wa_data = '1; wn_idx = 4'd7; wn_data = '1;
        step(); step();
        #1; chk("R9 idle hold", ra0_data, 64'hAAAA_BBBB_CCCC_DDDD);
        step();
        // Mixed traffic against the model
        for (int c = 0; c < 400; c++) begin
            wa_en   = ($urandom % 3) == 0;
            wa_idx  = 6'($urandom);
            wa_data = {$urandom, $urandom};
            wn_en   = ($urandom % 3) == 0;
            wn_idx  = 4'($urandom);
            wn_data = $urandom;
            ra0_idx = 6'($urandom);
            ra1_idx = (c % 5 == 0) ? 6'd63 : 6'($urandom);
            rn_idx  = 4'($urandom);
            step();
        end
        idle_in();
        step();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4ns * 200000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule